// File: doc/BRIEF.md
# Serial Line Bit-Period Meter

This block works out the bit rate of an incoming serial stream from a calibration character. It then produces the matching 16-bit divisor for a baud-rate generator. Software arms it with a one-cycle request. The unit then waits for the next start bit on the (already synchronized) receive line. It times that character and presents the result on a divisor bus with a one-cycle load strobe. On completion it drops its armed indication by itself, so each arming covers exactly one character.

The calibration character is 0x55, sent least significant bit first. The start bit and the data bits therefore alternate, and the line shows five falling edges spaced two bit times apart. The unit counts system clocks from the first of these edges to the fifth, a span of eight bit times. It divides that span by 128 when the generator uses 16x oversampling and by 32 when it uses 4x oversampling. It rounds to nearest and subtracts one. An optional inversion of the receive line is applied before edge detection. If the count saturates before the fifth edge, the unit gives up, flags an overflow and disarms.

Top module: `autobaud_meter`

## Requirements
- R1: After reset, `armed`, `overflow`, `div_load` and `done` are 0 and `div_out` is 0.
- R2: A one-cycle `arm_set` pulse while unarmed sets `armed` to 1 from the next cycle. It stays 1 until the measurement finishes, and then returns to 0 without any software action.
- R3: While unarmed, falling edges on the receive line cause no `div_load`, and `div_out` keeps its value.
- R4: With `hi_speed` = 0, the divisor is round(N/128) − 1. N is the number of clocks between the cycle that samples the first falling edge and the cycle that samples the fifth. `div_load` pulses for one cycle, in the cycle after the fifth edge is sampled, with `div_out` already holding the new value.
- R5: With `hi_speed` = 1, the divisor is round(N/32) − 1, with the same timing as R4.
- R6: When the rounded quotient is 0 (N below 64 for 16x, below 16 for 4x), the divisor loaded is 0.
- R7: Only one character is measured per arming. A second 0x55 frame that follows a completed measurement causes no `div_load`.
- R8: With `rx_invert` = 1, the line is inverted before edge detection: the idle level is 0 and the falling edges are rising edges at the pin. The divisor is the same as for the non-inverted frame.
- R9: If 65535 clocks pass after the first edge without the fifth edge, the unit sets `overflow`, clears `armed` and gives no `div_load`. The next `arm_set` clears `overflow`.
- R10: An `arm_set` that arrives in the same cycle as the fifth edge still gives that character's `div_load`. The unit is then left armed, so the following character is measured too.
- R11: `done` pulses for one cycle at every completion, whether a divisor was loaded or the count overflowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Synchronized receive line |
| rx_invert | input | 1 | 1: invert the line before edge detection |
| arm_set | input | 1 | One-cycle request to arm a measurement |
| hi_speed | input | 1 | 0: 16x oversampling divisor, 1: 4x |
| armed | output | 1 | Measurement pending; cleared by hardware on completion |
| div_load | output | 1 | One-cycle strobe, `div_out` valid |
| div_out | output | 16 | Measured divisor for the baud-rate generator |
| done | output | 1 | One-cycle pulse when a measurement ends |
| overflow | output | 1 | Count saturated before the fifth edge |

## Verification
Two events can fall in the same cycle: the end of a measurement (the fifth falling edge) and a fresh arm request. The bench raises `arm_set` on exactly the clock where it drives the final falling edge of a frame. It then expects a load strobe carrying that frame's divisor, `armed` still high afterwards, and a second load from the next frame sent without re-arming. A wrong priority shows up in one of two ways: the first result is lost, or the unit is left disarmed.

// File: rtl/abm_pkg.sv
package abm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MEAS = 2'd2
    } meas_state_e;

endpackage

// File: rtl/abm_fall_det.sv
module abm_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    input  logic invert,
    output logic fall
);
    typedef struct packed {
        logic prev;
    } det_t;

    det_t n_d, n_q;
    logic line;

    always_comb begin
        line     = line_raw ^ invert;
        n_d      = n_q;
        n_d.prev = line;
        fall     = n_q.prev & ~line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '{prev: 1'b1};
        else        n_q <= n_d;
    end
endmodule

// File: rtl/abm_div_calc.sv
module abm_div_calc #(
    parameter int SPAN_W = 17,
    parameter int DIV_W  = 16,
    parameter int SH_LO  = 7,
    parameter int SH_HI  = 5
) (
    input  logic [SPAN_W-1:0] span,
    input  logic              hi_speed,
    output logic [DIV_W-1:0]  divisor
);
    localparam int SUM_W = SPAN_W + 1;

    logic [SUM_W-1:0] sum_lo, sum_hi, quot;

    always_comb begin
        sum_lo = {1'b0, span} + SUM_W'(1 << (SH_LO - 1));
        sum_hi = {1'b0, span} + SUM_W'(1 << (SH_HI - 1));
        quot   = hi_speed ? (sum_hi >> SH_HI) : (sum_lo >> SH_LO);
        if (quot == '0) divisor = '0;
        else            divisor = DIV_W'(quot - SUM_W'(1));
    end
endmodule

// File: rtl/autobaud_meter.sv
module autobaud_meter #(
    parameter int CNT_W      = 16,
    parameter int DIV_W      = 16,
    parameter int FALL_EDGES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_in,
    input  logic             rx_invert,
    input  logic             arm_set,
    input  logic             hi_speed,
    output logic             armed,
    output logic             div_load,
    output logic [DIV_W-1:0] div_out,
    output logic             done,
    output logic             overflow
);
    import abm_pkg::*;

    localparam int                SPAN_W   = CNT_W + 1;
    localparam int                EDGE_W   = $clog2(FALL_EDGES);
    localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
    localparam logic [EDGE_W-1:0] LAST_IDX = EDGE_W'(FALL_EDGES - 2);

    typedef struct packed {
        meas_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [EDGE_W-1:0] idx;
        logic              ovf;
        logic              load;
        logic              fin;
        logic [DIV_W-1:0]  div;
    } ctl_t;

    ctl_t              c_d, c_q;
    logic              fall;
    logic [SPAN_W-1:0] span;
    logic [DIV_W-1:0]  div_calc;

    abm_fall_det u_fall (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_raw (rx_in),
        .invert   (rx_invert),
        .fall     (fall)
    );

    assign span = {1'b0, c_q.cnt} + SPAN_W'(1);

    abm_div_calc #(
        .SPAN_W (SPAN_W),
        .DIV_W  (DIV_W),
        .SH_LO  (7),
        .SH_HI  (5)
    ) u_div (
        .span     (span),
        .hi_speed (hi_speed),
        .divisor  (div_calc)
    );

    always_comb begin
        c_d      = c_q;
        c_d.load = 1'b0;
        c_d.fin  = 1'b0;
        unique case (c_q.st)
            ST_IDLE: ;
            ST_WAIT: begin
                if (fall) begin
                    c_d.st  = ST_MEAS;
                    c_d.cnt = '0;
                    c_d.idx = '0;
                end
            end
            ST_MEAS: begin
                c_d.cnt = c_q.cnt + CNT_W'(1);
                if (fall) begin
                    if (c_q.idx == LAST_IDX) begin
                        c_d.load = 1'b1;
                        c_d.fin  = 1'b1;
                        c_d.div  = div_calc;
                        c_d.st   = ST_IDLE;
                    end else begin
                        c_d.idx = c_q.idx + EDGE_W'(1);
                    end
                end else if (c_q.cnt == CNT_MAX) begin
                    c_d.ovf = 1'b1;
                    c_d.fin = 1'b1;
                    c_d.st  = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
        // an arm request lands after completion handling, so a finish and a re-arm can share a cycle
        if (arm_set && c_d.st == ST_IDLE) begin
            c_d.st = ST_WAIT;
            if (c_q.st == ST_IDLE) c_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, cnt: '0, idx: '0, ovf: 1'b0,
                            load: 1'b0, fin: 1'b0, div: '0};
        else        c_q <= c_d;
    end

    assign armed    = (c_q.st != ST_IDLE);
    assign div_load = c_q.load;
    assign div_out  = c_q.div;
    assign done     = c_q.fin;
    assign overflow = c_q.ovf;

    // R11
    load_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |-> done);

    // R9
    ovf_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> (done && !div_load && !armed));

    // R3
    no_load_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !div_load);

    // R2
    disarm_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(armed) |-> done);

    // R3
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !div_load |-> $stable(div_out));
endmodule

// File: tb/autobaud_meter_tb.sv
module autobaud_meter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_in = 1'b1;
    logic        rx_invert = 1'b0;
    logic        arm_set = 1'b0;
    logic        hi_speed = 1'b0;
    logic        armed, div_load, done, overflow;
    logic [15:0] div_out;

    int n_chk = 0;
    int n_bad = 0;
    int n_load = 0;
    int n_done = 0;
    int last_div = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    autobaud_meter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_in     (rx_in),
        .rx_invert (rx_invert),
        .arm_set   (arm_set),
        .hi_speed  (hi_speed),
        .armed     (armed),
        .div_load  (div_load),
        .div_out   (div_out),
        .done      (done),
        .overflow  (overflow)
    );

    always @(negedge clk) begin
        if (div_load) begin
            n_load++;
            last_div = int'(div_out);
        end
        if (done) n_done++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_div(input int bitlen, input bit fast);
        int span = 8 * bitlen;
        int den  = fast ? 32 : 128;
        int q    = (2 * span + den) / (2 * den);
        return (q == 0) ? 0 : q - 1;
    endfunction

    task automatic pulse_arm();
        arm_set = 1'b1;
        @(negedge clk);
        arm_set = 1'b0;
    endtask

    // 0x55, LSB first: start, 1,0,1,0,1,0,1,0, stop
    task automatic send_sync(input int bitlen, input bit inv, input bit arm_end);
        for (int i = 0; i < 10; i++) begin
            bit v = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : ((i % 2) == 1);
            rx_in = v ^ inv;
            if (arm_end && i == 8) arm_set = 1'b1;
            @(negedge clk);
            arm_set = 1'b0;
            repeat (bitlen - 1) @(negedge clk);
        end
        rx_in = ~inv;
        repeat (4) @(negedge clk);
    endtask

    task automatic measure(input int bitlen, input bit fast, input bit inv, input string req);
        int l0 = n_load;
        int d0 = n_done;
        hi_speed  = fast;
        rx_invert = inv;
        rx_in     = ~inv;
        repeat (2) @(negedge clk);
        pulse_arm();
        check({req, " armed"}, int'(armed), 1);
        send_sync(bitlen, inv, 1'b0);
        check({req, " one load"}, n_load - l0, 1);
        check({req, " divisor"}, last_div, exp_div(bitlen, fast));
        check({req, " R2 self-clear"}, int'(armed), 0);
        check({req, " R11 done"}, n_done - d0, 1);
    endtask

    initial begin
        int l0, d0, dv;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        // R1
        check("R1 armed", int'(armed), 0);
        check("R1 overflow", int'(overflow), 0);
        check("R1 div_out", int'(div_out), 0);
        check("R1 div_load", int'(div_load), 0);
        check("R1 done", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: frame while unarmed
        send_sync(40, 1'b0, 1'b0);
        check("R3 no load", n_load, 0);
        check("R3 div kept", int'(div_out), 0);

        measure(100, 1'b0, 1'b0, "R4 16x directed");
        measure(50,  1'b1, 1'b0, "R5 4x directed");
        measure(4,   1'b0, 1'b0, "R6 clamp 16x");
        measure(1,   1'b1, 1'b0, "R6 clamp 4x");
        measure(8,   1'b0, 1'b0, "R4 tie round");
        measure(77,  1'b0, 1'b1, "R8 inverted 16x");
        measure(33,  1'b1, 1'b1, "R8 inverted 4x");

        for (int k = 0; k < 8; k++) begin
            bit fast = 1'($urandom_range(0, 1));
            int b    = fast ? int'($urandom_range(6, 400)) : int'($urandom_range(20, 400));
            measure(b, fast, 1'($urandom_range(0, 1)), fast ? "R5 random" : "R4 random");
        end

        // R7: next frame without arming
        rx_invert = 1'b0;
        rx_in = 1'b1;
        dv = last_div;
        l0 = n_load;
        send_sync(60, 1'b0, 1'b0);
        check("R7 no second load", n_load - l0, 0);
        check("R7 div kept", int'(div_out), dv);

        // R10: arm in the cycle of the final edge
        hi_speed = 1'b0;
        pulse_arm();
        l0 = n_load;
        send_sync(90, 1'b0, 1'b1);
        check("R10 load", n_load - l0, 1);
        check("R10 divisor", last_div, exp_div(90, 1'b0));
        check("R10 still armed", int'(armed), 1);
        send_sync(130, 1'b0, 1'b0);
        check("R10 second load", n_load - l0, 2);
        check("R10 second divisor", last_div, exp_div(130, 1'b0));
        check("R10 disarmed", int'(armed), 0);

        // R9: one falling edge, then silence
        pulse_arm();
        l0 = n_load;
        d0 = n_done;
        dv = int'(div_out);
        rx_in = 1'b0;
        repeat (10) @(negedge clk);
        rx_in = 1'b1;
        repeat (65600) @(negedge clk);
        check("R9 overflow set", int'(overflow), 1);
        check("R9 disarmed", int'(armed), 0);
        check("R9 no load", n_load - l0, 0);
        check("R9 div kept", int'(div_out), dv);
        check("R11 done on overflow", n_done - d0, 1);
        pulse_arm();
        check("R9 overflow cleared by arm", int'(overflow), 0);
        check("R2 re-armed", int'(armed), 1);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule